// File: doc/BRIEF.md
# Down-counting interval timer

A single-channel interval timer for a system bus. Software loads an interval value and a control word through a small word-addressed register port. Once started, the timer copies the interval into its counter and counts down by one on every prescaled tick of a selected source. Each time the count reaches zero, a sticky pending flag is raised and, when the interrupt is enabled, drives the interrupt output. In continuous mode the counter reloads itself and keeps running. In single mode the timer switches itself off at zero.

The two source clocks are modelled as one-cycle tick enables on the system clock. A power-of-two prescaler sits between the selected tick and the counter. Clearing the enable bit pauses the count without losing it, and a later start resumes from the held value. A self-clearing reload bit copies the interval into the counter on demand. Setting reload together with enable restarts the count from a freshly written interval. A short guard window after a stop rejects an early restart. The core is a four-state machine: `ST_IDLE` (stopped, ready), `ST_RUN` (counting), `ST_COOL_A` and `ST_COOL_B` (the two guard cycles after enable drops). Its transitions are *start* (IDLE to RUN), *stop* and *single finish* (RUN to COOL_A), *cool step* (COOL_A to COOL_B) and *cool done* (COOL_B to IDLE).

Register map (word address on `reg_addr`): 0 = control, 1 = interval, 2 = current value (read-only), 3 = status. Control fields: bit 0 enable, bit 1 reload, bits 3:2 source, bits 6:4 prescale, bit 7 mode. Status fields: bit 0 pending (write 1 to clear), bit 1 interrupt enable.

Top module: `ivt_top`

## Requirements
- R1: After reset, control reads 0x0000_0004 (source code 01, all else 0), interval, current value and status read 0, and `irq` is 0.
- R2: A start (a control write with bit 0 = 1 in `ST_IDLE`) while the current value is 0 loads the interval. While running, the current value then drops by exactly one per prescaled tick, and the prescaler restarts on every start.
- R3: Source code 00 takes ticks from `tick_lo`, code 01 from `tick_hi`, and codes 10 and 11 give no ticks, so the count does not move.
- R4: Prescale code p (bits 6:4) makes one decrement for every 2^p ticks of the selected source, for p = 0 to 7.
- R5: In continuous mode (bit 7 = 0), the decrement that reaches 0 sets pending. In the next cycle the counter reloads the interval, the prescaler restarts, and the timer stays enabled.
- R6: In single mode (bit 7 = 1), the decrement that reaches 0 sets pending and clears the enable bit. The current value then stays 0 whatever ticks arrive.
- R7: A control write with bit 0 = 0 while running pauses the count: the current value holds, and the enable bit reads 0. A later start resumes from the held value without loading the interval.
- R8: A control write with bit 0 = 1 in either of the two cycles after the cycle in which enable was cleared is ignored (enable stays 0). The same write one cycle later starts the timer.
- R9: A control write with bit 1 = 1 copies the interval into the counter at once. Bit 1 then reads 1 for exactly one cycle and returns to 0. A reload write that arrives while bit 1 reads 1 has no effect.
- R10: While paused, writing a new interval leaves the current value unchanged. A single write with bits 0 and 1 both set then restarts the count from the new interval.
- R11: Pending stays set until a status write with bit 0 = 1 clears it. Status bit 1 is the interrupt enable, and `irq` equals pending AND interrupt enable.
- R12: Control bits 31:8 read 0 and ignore writes. Writes to the current-value address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_lo | input | 1 | Low-frequency source tick enable |
| tick_hi | input | 1 | High-frequency source tick enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are the two cycle-exact windows. The first is the pair of guard cycles after a stop, and the second is the single cycle in which the reload bit is busy. Both are reached with control writes on consecutive clock cycles and no idle cycle between them. For the reload case, `tick_hi` is held high through both writes, so that the count differs by one according to whether the second reload was obeyed. The wrap in continuous mode, the stop in single mode and the largest prescale are reached by walking a table of tick counts. The expected current values in that table are worked out from the tick arithmetic.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int PRES_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_IVAL = 2'd1;
    localparam logic [ADDR_W-1:0] A_CUR  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int B_EN   = 0;
    localparam int B_RLD  = 1;
    localparam int B_SRC  = 2;
    localparam int B_PRES = 4;
    localparam int B_MODE = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_COOL_A = 2'd2,
        ST_COOL_B = 2'd3
    } ivt_state_e;

    typedef struct packed {
        logic              mode;
        logic [PRES_W-1:0] pres;
        logic [1:0]        src;
    } ivt_cfg_t;
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_lo,
    input  logic              tick_hi,
    input  logic [1:0]        src_sel,
    input  logic [PRES_W-1:0] pres_sel,
    input  logic              run,
    input  logic              clr,
    output logic              step
);
    localparam int PC_W = (1 << PRES_W) - 1;

    logic [PC_W-1:0] pre_cnt;
    logic [PC_W-1:0] mask;
    logic            src_tick;

    // Terminal count for divide-by-2^p is a run of p ones.
    for (genvar i = 0; i < PC_W; i++) begin : g_mask
        assign mask[i] = (pres_sel > PRES_W'(i));
    end

    always_comb begin
        unique case (src_sel)
            2'b00:   src_tick = tick_lo;
            2'b01:   src_tick = tick_hi;
            default: src_tick = 1'b0;
        endcase
    end

    // pre_cnt may exceed mask after a prescale change mid-run; >= wraps it.
    assign step = run & src_tick & (pre_cnt >= mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clr) begin
            pre_cnt <= '0;
        end else if (run && src_tick) begin
            pre_cnt <= step ? '0 : pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] value,
    output logic             zero,
    output logic             one
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (dec) begin
            value <= value - 1'b1;
        end
    end

    assign zero = (value == '0);
    assign one  = (value == CNT_W'(1));
endmodule

// File: rtl/ivt_ctrl_fsm.sv
module ivt_ctrl_fsm
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_en_bit,
    input  logic wr_rld_bit,
    input  logic rld_busy,
    input  logic mode_single,
    input  logic step,
    input  logic cnt_zero,
    input  logic cnt_one,
    output logic run,
    output logic cnt_load,
    output logic cnt_dec,
    output logic pre_clr,
    output logic hit,
    output logic reload_go
);
    ivt_state_e state, nxt;
    logic start_ok, stop_req;

    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin : decode
        start_ok  = ctl_wr & wr_en_bit  & (state == ST_IDLE);
        stop_req  = ctl_wr & ~wr_en_bit & (state == ST_RUN);
        reload_go = ctl_wr & wr_rld_bit & ~rld_busy;
    end

    always_comb begin : next_state
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_ok) nxt = ST_RUN;
            ST_RUN: begin
                if (stop_req)
                    nxt = ST_COOL_A;
                else if (mode_single && (hit || (cnt_zero && !reload_go)))
                    nxt = ST_COOL_A;
            end
            ST_COOL_A: nxt = ST_COOL_B;
            ST_COOL_B: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin : outputs
        run      = (state == ST_RUN);
        cnt_load = reload_go
                 | (start_ok & cnt_zero)
                 | (run & ~stop_req & cnt_zero & ~mode_single);
        cnt_dec  = run & ~stop_req & step & ~cnt_zero & ~cnt_load;
        pre_clr  = cnt_load | start_ok | ~run;
        hit      = cnt_dec & cnt_one;
    end
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              run,
    input  logic              reload_go,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cur,
    output ivt_cfg_t          cfg,
    output logic [CNT_W-1:0]  interval,
    output logic              pend,
    output logic              ie,
    output logic              rld_busy,
    output logic              ctl_wr,
    output logic              wr_en_bit,
    output logic              wr_rld_bit,
    output logic [DATA_W-1:0] reg_rdata
);
    logic ival_wr, stat_wr;

    assign ctl_wr     = reg_wr & (reg_addr == A_CTRL);
    assign ival_wr    = reg_wr & (reg_addr == A_IVAL);
    assign stat_wr    = reg_wr & (reg_addr == A_STAT);
    assign wr_en_bit  = reg_wdata[B_EN];
    assign wr_rld_bit = reg_wdata[B_RLD];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '{mode: 1'b0, pres: '0, src: 2'b01};
            interval <= '0;
            ie       <= 1'b0;
            pend     <= 1'b0;
            rld_busy <= 1'b0;
        end else begin
            rld_busy <= reload_go;
            if (ctl_wr) begin
                cfg.mode <= reg_wdata[B_MODE];
                cfg.pres <= reg_wdata[B_PRES +: PRES_W];
                cfg.src  <= reg_wdata[B_SRC +: 2];
            end
            if (ival_wr) interval <= reg_wdata[CNT_W-1:0];
            if (stat_wr) ie <= reg_wdata[1];
            if (hit)
                pend <= 1'b1;
            else if (stat_wr && reg_wdata[0])
                pend <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]             = run;
                reg_rdata[B_RLD]            = rld_busy;
                reg_rdata[B_SRC +: 2]       = cfg.src;
                reg_rdata[B_PRES +: PRES_W] = cfg.pres;
                reg_rdata[B_MODE]           = cfg.mode;
            end
            A_IVAL:  reg_rdata = DATA_W'(interval);
            A_CUR:   reg_rdata = DATA_W'(cur);
            A_STAT:  reg_rdata[1:0] = {ie, pend};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_lo,
    input  logic              tick_hi,
    output logic              irq
);
    ivt_cfg_t         cfg;
    logic [CNT_W-1:0] interval, cur;
    logic             pend, ie, rld_busy;
    logic             ctl_wr, wr_en_bit, wr_rld_bit;
    logic             run, cnt_load, cnt_dec, pre_clr, hit, reload_go;
    logic             step, cnt_zero, cnt_one;

    ivt_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .run(run), .reload_go(reload_go), .hit(hit),
        .cur(cur), .cfg(cfg), .interval(interval), .pend(pend), .ie(ie),
        .rld_busy(rld_busy), .ctl_wr(ctl_wr), .wr_en_bit(wr_en_bit),
        .wr_rld_bit(wr_rld_bit), .reg_rdata(reg_rdata)
    );

    ivt_ctrl_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_en_bit(wr_en_bit),
        .wr_rld_bit(wr_rld_bit), .rld_busy(rld_busy), .mode_single(cfg.mode),
        .step(step), .cnt_zero(cnt_zero), .cnt_one(cnt_one), .run(run),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec), .pre_clr(pre_clr), .hit(hit),
        .reload_go(reload_go)
    );

    ivt_prescale i_pre (
        .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi),
        .src_sel(cfg.src), .pres_sel(cfg.pres), .run(run), .clr(pre_clr),
        .step(step)
    );

    ivt_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .dec(cnt_dec),
        .load_val(interval), .value(cur), .zero(cnt_zero), .one(cnt_one)
    );

    assign irq = pend & ie;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wdata0,
    input logic             run,
    input logic             cnt_load,
    input logic             hit,
    input logic             mode_single,
    input logic [1:0]       src,
    input logic             rld_busy,
    input logic             pend,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] interval
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cur == $past(cur) || cur == $past(cur) - 1'b1 || cur == $past(interval)));

    assert_reserved_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src[1] && !cnt_load) |=> $stable(cur));

    assert_single_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_single && hit) |=> (!run && cur == '0));

    assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_load) |=> $stable(cur));

    assert_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |=> !run ##1 !run);

    assert_reload_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rld_busy |=> !rld_busy);

    assert_pend_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(reg_wr && reg_addr == 2'd3 && wdata0)) |=> pend);
endmodule

bind ivt_top ivt_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata0(reg_wdata[0]), .run(run), .cnt_load(cnt_load), .hit(hit),
    .mode_single(cfg.mode), .src(cfg.src), .rld_busy(rld_busy), .pend(pend),
    .cur(cur), .interval(interval)
);

// File: tb/test_ivt_top.sv
`timescale 1ns/100ps
module test_ivt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_lo = 1'b0;
    logic        tick_hi = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] C_EN  = 32'h1;
    localparam logic [31:0] C_RLD = 32'h2;
    localparam logic [31:0] C_HI  = 32'h4;

    always #2.5 clk = ~clk;

    ivt_top i_ivt_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_lo(tick_lo),
        .tick_hi(tick_hi), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] ival;
        logic [1:0]  src;
        logic [2:0]  pres;
        logic        mode;
        logic        on_hi;
        logic [7:0]  n;
        logic [15:0] cur;
        logic        pend;
        logic        en;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'd10, 2'b01, 3'd0, 1'b0, 1'b1, 8'd3,   16'd7,  1'b0, 1'b1}, // R2
        '{16'd10, 2'b01, 3'd2, 1'b0, 1'b1, 8'd9,   16'd8,  1'b0, 1'b1}, // R4
        '{16'd5,  2'b00, 3'd0, 1'b0, 1'b0, 8'd4,   16'd1,  1'b0, 1'b1}, // R3
        '{16'd5,  2'b00, 3'd0, 1'b0, 1'b1, 8'd4,   16'd5,  1'b0, 1'b1}, // R3
        '{16'd5,  2'b10, 3'd0, 1'b0, 1'b1, 8'd4,   16'd5,  1'b0, 1'b1}, // R3
        '{16'd4,  2'b01, 3'd0, 1'b0, 1'b1, 8'd4,   16'd4,  1'b1, 1'b1}, // R5
        '{16'd4,  2'b01, 3'd0, 1'b0, 1'b1, 8'd6,   16'd2,  1'b1, 1'b1}, // R5
        '{16'd3,  2'b01, 3'd0, 1'b1, 1'b1, 8'd3,   16'd0,  1'b1, 1'b0}, // R6
        '{16'd3,  2'b01, 3'd0, 1'b1, 1'b1, 8'd5,   16'd0,  1'b1, 1'b0}, // R6
        '{16'd2,  2'b01, 3'd7, 1'b0, 1'b1, 8'd128, 16'd1,  1'b0, 1'b1}, // R4
        '{16'd3,  2'b01, 3'd1, 1'b0, 1'b1, 8'd7,   16'd3,  1'b1, 1'b1}  // R5
    };

    function automatic void check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input logic on_hi, input int n);
        for (int i = 0; i < n; i++) begin
            if (on_hi) tick_hi = 1'b1; else tick_lo = 1'b1;
            @(negedge clk);
            tick_hi = 1'b0; tick_lo = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic [31:0] ival, input logic [31:0] ctrl);
        wr(2'd0, 32'h0);
        idle(3);
        wr(2'd3, 32'h1);
        wr(2'd1, ival);
        wr(2'd0, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(2'd0, v); check("R1 ctrl", v, 32'h4);
        rd(2'd1, v); check("R1 interval", v, 0);
        rd(2'd2, v); check("R1 current", v, 0);
        rd(2'd3, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            restart({16'b0, VECS[k].ival},
                    C_EN | C_RLD | {24'b0, VECS[k].mode, VECS[k].pres, VECS[k].src, 2'b00});
            pulses(VECS[k].on_hi, int'(VECS[k].n));
            rd(2'd2, v); check($sformatf("vec%0d current (R2-table)", k), v, {16'b0, VECS[k].cur});
            rd(2'd3, v); check($sformatf("vec%0d pending", k), {31'b0, v[0]}, {31'b0, VECS[k].pend});
            rd(2'd0, v); check($sformatf("vec%0d enable", k), {31'b0, v[0]}, {31'b0, VECS[k].en});
        end

        // R7: pause holds, resume without reload
        restart(20, C_EN | C_RLD | C_HI);
        pulses(1'b1, 5);
        rd(2'd2, v); check("R7 before pause", v, 15);
        wr(2'd0, C_HI);
        rd(2'd0, v); check("R7 enable cleared", {31'b0, v[0]}, 0);
        pulses(1'b1, 3);
        rd(2'd2, v); check("R7 held while paused", v, 15);
        wr(2'd0, C_EN | C_HI);
        rd(2'd2, v); check("R7 resume no reload", v, 15);
        pulses(1'b1, 2);
        rd(2'd2, v); check("R7 resumed count", v, 13);

        // R8: early set ignored for two cycles
        wr(2'd0, C_HI);
        wr(2'd0, C_EN | C_HI);
        rd(2'd0, v); check("R8 first cycle ignored", {31'b0, v[0]}, 0);
        wr(2'd0, C_EN | C_HI);
        rd(2'd0, v); check("R8 second cycle ignored", {31'b0, v[0]}, 0);
        wr(2'd0, C_EN | C_HI);
        rd(2'd0, v); check("R8 third cycle accepted", {31'b0, v[0]}, 1);

        // R9: reload bit pulse and ignore while busy
        restart(50, C_EN | C_RLD | C_HI);
        rd(2'd0, v); check("R9 reload bit set", {31'b0, v[1]}, 1);
        @(negedge clk);
        rd(2'd0, v); check("R9 reload bit cleared", {31'b0, v[1]}, 0);
        @(negedge clk);
        tick_hi = 1'b1;
        wr(2'd0, C_EN | C_RLD | C_HI);
        wr(2'd0, C_EN | C_RLD | C_HI);
        tick_hi = 1'b0;
        rd(2'd2, v); check("R9 second reload ignored", v, 49);

        // R10: new interval while paused, reload+enable restart
        restart(30, C_EN | C_RLD | C_HI);
        pulses(1'b1, 4);
        wr(2'd0, C_HI);
        idle(3);
        wr(2'd1, 9);
        rd(2'd2, v); check("R10 interval write leaves count", v, 26);
        wr(2'd0, C_EN | C_RLD | C_HI);
        rd(2'd2, v); check("R10 restart from new interval", v, 9);
        pulses(1'b1, 1);
        rd(2'd2, v); check("R10 counts from new interval", v, 8);

        // R11: pending, interrupt enable, clear
        restart(2, C_EN | C_RLD | C_HI);
        pulses(1'b1, 2);
        rd(2'd3, v); check("R11 pending set", v, 32'h1);
        check("R11 irq masked", {31'b0, irq}, 0);
        wr(2'd3, 32'h2);
        rd(2'd3, v); check("R11 pending kept", v, 32'h3);
        check("R11 irq raised", {31'b0, irq}, 1);
        wr(2'd3, 32'h3);
        rd(2'd3, v); check("R11 pending cleared", v, 32'h2);
        check("R11 irq dropped", {31'b0, irq}, 0);

        // R12: upper control bits and read-only current value
        wr(2'd0, 32'hFFFF_FF70);
        rd(2'd0, v); check("R12 upper ctrl bits", v, 32'h70);
        wr(2'd2, 32'h1234);
        rd(2'd2, v); check("R12 current read-only", v, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule